// File: doc/BRIEF.md
# Single-Wire Debug Sync and Handshake Responder

This block sits on the target side of a one-wire, open-drain debug line. The host can ask the target to reveal its debug clock rate. It does this by holding the line low for a long time and then letting it go. The responder then answers with a reply whose low phase has a fixed length in debug-clock cycles. The host times that low phase and derives the bit rate it should use from then on. Every low phase the target drives ends with one actively driven high cycle, which gives the line a sharp rising edge. After that cycle the target releases the line.

The responder also watches the command bytes that a separate bit receiver delivers. Two byte values turn a handshake-enable flag on and off. No processor takes part in this. While the flag is on, the target marks the end of each command with a short low acknowledge pulse, started by a command-done strobe from the rest of the debug logic. The enable command acknowledges itself. The line is modelled as a sampled input plus drive-enable and drive-value outputs. Sync replies and the two handshake bytes are honoured in every operating mode, whatever the processor is doing.

Top module: `dbgpin_responder`

## Requirements
- R1: After synchronous reset the line is released (`drv_en`=0), `busy`=0 and the handshake flag `hs_en`=0.
- R2: A sync request is recognised only when `pin_in` is sampled low for at least SYNC_MIN_LOW (128) consecutive cycles and is then sampled high. A low run of 127 cycles produces no reply.
- R3: A sync reply raises `busy` two cycles after the first high sample. The line then stays released for SYNC_GAP (16) cycles, after which it is driven low (`drv_en`=1, `drv_val`=0) for exactly SYNC_LOW (128) cycles.
- R4: Every driven low phase is followed at once by exactly one cycle with `drv_en`=1 and `drv_val`=1. After that cycle the line is released and `busy` falls.
- R5: A command byte of 0x02 sets `hs_en`. It also produces an acknowledge pulse with no `cmd_done` strobe.
- R6: A command byte of 0x03 clears `hs_en` and is not followed by an acknowledge pulse.
- R7: With `hs_en`=1, a `cmd_done` strobe starts an acknowledge pulse. `busy` rises in the next cycle, the line stays released for one idle cycle, and then the line is driven low for ACK_LOW (16) cycles.
- R8: With `hs_en`=0, a `cmd_done` strobe produces no pulse.
- R9: `busy` is high whenever the line is driven. `cmd_valid` and `cmd_done` strobes that arrive while `busy` is high are dropped and leave `hs_en` unchanged.
- R10: Low samples taken while `busy` is high do not count toward a sync request. A host low that overlaps an acknowledge pulse counts only the cycles after `busy` falls.
- R11: Command byte values other than 0x02 and 0x03 leave `hs_en` unchanged and start no pulse by themselves.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Debug clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | 1 | Sampled level of the debug line |
| cmd_valid | input | 1 | One-cycle strobe: a command byte has been received |
| cmd_byte | input | CMD_W (8) | Received command byte |
| cmd_done | input | 1 | One-cycle strobe: the current command has finished |
| drv_en | output | 1 | Target drives the line when high |
| drv_val | output | 1 | Level driven while `drv_en` is high |
| busy | output | 1 | A reply or acknowledge sequence is in progress |
| hs_en | output | 1 | Handshake-enable flag |

## Verification
The bench probes the sync threshold at 127 and 128 low cycles and with a much longer low run. A detector that is off by one would either answer the short run or miss the exact one. The bench measures every phase of each pulse: latency, released gap, low length and speed-up length. A sequencer that reuses the wrong length, or drops or doubles the high cycle, shows up as a wrong count. The bench checks that 0x03 and an unrelated byte stay silent, and that `cmd_done` is acknowledged only while the flag is set. A decoder that treats every byte alike, or that acknowledges the disable command, therefore fails. Finally, the bench sends strobes and a long host low while the target is busy. A design that latches strobes during a pulse would show a changed flag. One that keeps counting its own drive as a host low would answer with a spurious sync reply.

// File: rtl/dbgpin_pkg.sv
package dbgpin_pkg;

  // Pulse sequencer phases
  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_GAP  = 2'd1,
    SQ_LOW  = 2'd2,
    SQ_KICK = 2'd3
  } seq_state_t;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/dbgpin_sync_detect.sv
module dbgpin_sync_detect #(
  parameter int MIN_LOW = 128
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_in,
  input  logic hold,
  output logic sync_req
);
  localparam int CW = $clog2(MIN_LOW + 1);
  localparam logic [CW-1:0] LOW_SAT = CW'(MIN_LOW);

  logic [CW-1:0] low_run;

  // Count consecutive low samples (saturating); fire on the first high sample
  always_ff @(posedge clk) begin
    if (rst) begin
      low_run  <= '0;
      sync_req <= 1'b0;
    end else begin
      sync_req <= 1'b0;
      if (hold) begin
        low_run <= '0;
      end else if (!pin_in) begin
        if (low_run != LOW_SAT) low_run <= low_run + 1'b1;
      end else begin
        sync_req <= (low_run == LOW_SAT);
        low_run  <= '0;
      end
    end
  end

endmodule

// File: rtl/dbgpin_cmd_decode.sv
module dbgpin_cmd_decode #(
  parameter int              CMD_W    = 8,
  parameter logic [CMD_W-1:0] CODE_ON  = 8'h02,
  parameter logic [CMD_W-1:0] CODE_OFF = 8'h03
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             accept,
  input  logic             cmd_valid,
  input  logic [CMD_W-1:0] cmd_byte,
  input  logic             cmd_done,
  output logic             hs_en,
  output logic             ack_req
);
  logic take, is_on, is_off;

  always_comb begin
    take    = accept && cmd_valid;
    is_on   = take && (cmd_byte == CODE_ON);
    is_off  = take && (cmd_byte == CODE_OFF);
    // Enable acknowledges itself; a disable in the same cycle suppresses done
    ack_req = is_on || (accept && cmd_done && hs_en && !is_off);
  end

  always_ff @(posedge clk) begin
    if (rst)         hs_en <= 1'b0;
    else if (is_on)  hs_en <= 1'b1;
    else if (is_off) hs_en <= 1'b0;
  end

endmodule

// File: rtl/dbgpin_pulse_seq.sv
module dbgpin_pulse_seq
  import dbgpin_pkg::*;
#(
  parameter int SYNC_GAP = 16,
  parameter int SYNC_LOW = 128,
  parameter int ACK_IDLE = 1,
  parameter int ACK_LOW  = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic start_sync,
  input  logic start_ack,
  output logic drv_en,
  output logic drv_val,
  output logic busy
);
  localparam int MAXLEN = max3(SYNC_GAP, SYNC_LOW, max3(ACK_IDLE, ACK_LOW, 1));
  localparam int CW     = $clog2(MAXLEN + 1);

  seq_state_t    state;
  logic [CW-1:0] cnt;
  logic [CW-1:0] gap_last;
  logic [CW-1:0] low_last;

  assign busy = (state != SQ_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= SQ_IDLE;
      cnt      <= '0;
      gap_last <= '0;
      low_last <= '0;
      drv_en   <= 1'b0;
      drv_val  <= 1'b0;
    end else begin
      unique case (state)
        SQ_IDLE: begin
          cnt <= '0;
          if (start_sync) begin
            state    <= SQ_GAP;
            gap_last <= CW'(SYNC_GAP - 1);
            low_last <= CW'(SYNC_LOW - 1);
          end else if (start_ack) begin
            state    <= SQ_GAP;
            gap_last <= CW'(ACK_IDLE - 1);
            low_last <= CW'(ACK_LOW - 1);
          end
        end
        SQ_GAP: begin
          if (cnt == gap_last) begin
            state   <= SQ_LOW;
            cnt     <= '0;
            drv_en  <= 1'b1;
            drv_val <= 1'b0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        SQ_LOW: begin
          if (cnt == low_last) begin
            state   <= SQ_KICK;
            cnt     <= '0;
            drv_val <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        SQ_KICK: begin
          state   <= SQ_IDLE;
          drv_en  <= 1'b0;
          drv_val <= 1'b0;
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dbgpin_responder.sv
module dbgpin_responder #(
  parameter int               CMD_W        = 8,
  parameter logic [CMD_W-1:0] CODE_ON      = 8'h02,
  parameter logic [CMD_W-1:0] CODE_OFF     = 8'h03,
  parameter int               SYNC_MIN_LOW = 128,
  parameter int               SYNC_GAP     = 16,
  parameter int               SYNC_LOW     = 128,
  parameter int               ACK_IDLE     = 1,
  parameter int               ACK_LOW      = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pin_in,
  input  logic             cmd_valid,
  input  logic [CMD_W-1:0] cmd_byte,
  input  logic             cmd_done,
  output logic             drv_en,
  output logic             drv_val,
  output logic             busy,
  output logic             hs_en
);
  logic sync_req;
  logic ack_req;

  dbgpin_sync_detect #(.MIN_LOW(SYNC_MIN_LOW)) u_detect (
    .clk      (clk),
    .rst      (rst),
    .pin_in   (pin_in),
    .hold     (busy),
    .sync_req (sync_req)
  );

  dbgpin_cmd_decode #(.CMD_W(CMD_W), .CODE_ON(CODE_ON), .CODE_OFF(CODE_OFF)) u_decode (
    .clk       (clk),
    .rst       (rst),
    .accept    (!busy),
    .cmd_valid (cmd_valid),
    .cmd_byte  (cmd_byte),
    .cmd_done  (cmd_done),
    .hs_en     (hs_en),
    .ack_req   (ack_req)
  );

  dbgpin_pulse_seq #(
    .SYNC_GAP (SYNC_GAP),
    .SYNC_LOW (SYNC_LOW),
    .ACK_IDLE (ACK_IDLE),
    .ACK_LOW  (ACK_LOW)
  ) u_seq (
    .clk        (clk),
    .rst        (rst),
    .start_sync (sync_req),
    .start_ack  (ack_req),
    .drv_en     (drv_en),
    .drv_val    (drv_val),
    .busy       (busy)
  );

endmodule

// File: rtl/dbgpin_responder_chk.sv
module dbgpin_responder_chk #(
  parameter int               CMD_W    = 8,
  parameter logic [CMD_W-1:0] CODE_ON  = 8'h02,
  parameter logic [CMD_W-1:0] CODE_OFF = 8'h03,
  parameter int               SYNC_LOW = 128,
  parameter int               ACK_LOW  = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             drv_en,
  input logic             drv_val,
  input logic             busy,
  input logic             hs_en,
  input logic             cmd_valid,
  input logic [CMD_W-1:0] cmd_byte,
  input logic             sync_req
);
  int low_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      low_run <= 0;
    end else begin
      if (drv_en && !drv_val) low_run <= low_run + 1;
      else                    low_run <= 0;
      if (drv_en && drv_val)
        AST_LOW_LENGTH: assert (low_run == SYNC_LOW || low_run == ACK_LOW); // R3 R7
    end
  end

  AST_DRIVE_IMPLIES_BUSY: assert property (@(posedge clk) disable iff (rst)
    drv_en |-> busy); // R9

  AST_KICK_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (drv_en && drv_val) |=> !drv_en); // R4

  AST_LOW_THEN_KICK: assert property (@(posedge clk) disable iff (rst)
    (drv_en && !drv_val) |=> drv_en); // R4

  AST_FLAG_NEEDS_CMD: assert property (@(posedge clk) disable iff (rst)
    !cmd_valid |=> $stable(hs_en)); // R11

  AST_BUSY_DROPS_CMD: assert property (@(posedge clk) disable iff (rst)
    (busy && cmd_valid) |=> $stable(hs_en)); // R9

  AST_DISABLE_SILENT: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_byte == CODE_OFF && !busy && !sync_req) |=> !busy); // R6

  AST_FLAG_OFF_SILENT: assert property (@(posedge clk) disable iff (rst)
    (!hs_en && !busy && !sync_req && !(cmd_valid && cmd_byte == CODE_ON)) |=> !busy); // R8

endmodule

bind dbgpin_responder dbgpin_responder_chk #(
  .CMD_W    (CMD_W),
  .CODE_ON  (CODE_ON),
  .CODE_OFF (CODE_OFF),
  .SYNC_LOW (SYNC_LOW),
  .ACK_LOW  (ACK_LOW)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .drv_en    (drv_en),
  .drv_val   (drv_val),
  .busy      (busy),
  .hs_en     (hs_en),
  .cmd_valid (cmd_valid),
  .cmd_byte  (cmd_byte),
  .sync_req  (sync_req)
);

// File: tb/dbgpin_responder_bench.sv
module dbgpin_responder_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst;
  logic       host_low;
  logic       pin_in;
  logic       cmd_valid;
  logic [7:0] cmd_byte;
  logic       cmd_done;
  logic       drv_en, drv_val, busy, hs_en;

  int checks   = 0;
  int failures = 0;
  int cycles   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // Wired-AND open-drain line
  assign pin_in = !host_low && !(drv_en && !drv_val);

  dbgpin_responder u_dbgpin_responder (
    .clk       (clk),
    .rst       (rst),
    .pin_in    (pin_in),
    .cmd_valid (cmd_valid),
    .cmd_byte  (cmd_byte),
    .cmd_done  (cmd_done),
    .drv_en    (drv_en),
    .drv_val   (drv_val),
    .busy      (busy),
    .hs_en     (hs_en)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      chk(1'b0, "watchdog", cycles, 150000);
      finish_run();
    end
  end

  task automatic strobe_cmd(input logic [7:0] b);
    cmd_valid = 1'b1; cmd_byte = b;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_byte = 8'h00;
  endtask

  task automatic strobe_done();
    cmd_done = 1'b1;
    @(negedge clk);
    cmd_done = 1'b0;
  endtask

  task automatic host_pulse(input int n);
    host_low = 1'b1;
    repeat (n) @(negedge clk);
    host_low = 1'b0;
  endtask

  task automatic measure(output int lat, output int gap, output int low,
                         output int high, output bit clean);
    lat = 0; gap = 0; low = 0; high = 0;
    while (!busy && lat < 400) begin @(negedge clk); lat++; end
    while (busy && !drv_en) begin gap++; @(negedge clk); end
    while (drv_en && !drv_val) begin low++; @(negedge clk); end
    while (drv_en && drv_val) begin high++; @(negedge clk); end
    clean = !busy && !drv_en;
  endtask

  task automatic expect_quiet(input int n, input string req);
    int bad = 0;
    for (int i = 0; i < n; i++) begin
      if (busy || drv_en) bad++;
      @(negedge clk);
    end
    chk(bad == 0, req, bad, 0);
  endtask

  task automatic check_pulse(input string req, input int elat, input int egap, input int elow);
    int lat, gap, low, high;
    bit clean;
    measure(lat, gap, low, high, clean);
    chk(lat == elat, {req, " latency"}, lat, elat);
    chk(gap == egap, {req, " released gap"}, gap, egap);
    chk(low == elow, {req, " low length"}, low, elow);
    chk(high == 1, "R4 speed-up length", high, 1);
    chk(clean, "R4 release after speed-up", clean, 1);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(!drv_en && !busy && !hs_en, "R1 reset state",
        {29'd0, drv_en, busy, hs_en}, 0);
  endtask

  task automatic t_sync_short();
    host_pulse(127);
    expect_quiet(40, "R2 127-cycle low ignored");
  endtask

  task automatic t_sync_exact();
    host_pulse(128);
    check_pulse("R3 sync 128", 2, 16, 128);
  endtask

  task automatic t_sync_long();
    host_pulse(300);
    check_pulse("R2 sync 300", 2, 16, 128);
  endtask

  task automatic t_done_flag_off();
    strobe_done();
    expect_quiet(30, "R8 done with flag clear");
  endtask

  task automatic t_enable();
    strobe_cmd(8'h02);
    chk(hs_en, "R5 flag set by 0x02", hs_en, 1);
    check_pulse("R5 enable ack", 0, 1, 16);
  endtask

  task automatic t_done_ack();
    strobe_done();
    check_pulse("R7 done ack", 0, 1, 16);
    chk(hs_en, "R7 flag kept", hs_en, 1);
  endtask

  task automatic t_other_byte();
    strobe_cmd(8'h5A);
    expect_quiet(30, "R11 other byte no pulse");
    chk(hs_en, "R11 flag unchanged", hs_en, 1);
  endtask

  task automatic t_low_during_ack();
    strobe_done();
    chk(busy, "R10 ack started", busy, 1);
    host_pulse(140);
    expect_quiet(40, "R10 low during ack not counted");
  endtask

  task automatic t_disable();
    strobe_cmd(8'h03);
    chk(!hs_en, "R6 flag cleared by 0x03", hs_en, 0);
    expect_quiet(30, "R6 no ack after disable");
    strobe_done();
    expect_quiet(30, "R6 R8 done after disable silent");
  endtask

  task automatic t_busy_drop();
    int guard = 0;
    host_pulse(130);
    repeat (25) @(negedge clk);
    chk(busy, "R9 reply in progress", busy, 1);
    strobe_cmd(8'h02);
    strobe_done();
    while (busy && guard < 400) begin @(negedge clk); guard++; end
    chk(!hs_en, "R9 strobe while busy dropped", hs_en, 0);
    expect_quiet(30, "R9 no ack after dropped strobes");
  endtask

  initial begin
    host_low = 1'b0; cmd_valid = 1'b0; cmd_byte = 8'h00; cmd_done = 1'b0; rst = 1'b1;
    @(negedge clk);
    t_reset();
    t_sync_short();
    t_sync_exact();
    t_sync_long();
    t_done_flag_off();
    t_enable();
    t_done_ack();
    t_other_byte();
    t_low_during_ack();
    t_disable();
    t_busy_drop();
    finish_run();
  end

endmodule